// File: doc/BRIEF.md
# Clock-Delay Eye Centering Calibrator

This block picks the sampling point for a source-synchronous differential data link. The data lanes keep fixed delays, which only make up for lane-length skew. The forwarded clock goes through an adjustable delay element that has 32 positions. After a start request, the controller loads every clock delay position in turn, from the lowest to the highest. It waits a programmable number of settle cycles at each position, then compares a programmable number of consecutive deserialized words against a known training word, such as the converter's frame pattern. A position passes only when every compared word matches.

When the sweep is complete, the controller takes the first contiguous run of passing positions as the data eye. The lower and upper edges of that run bound the eye, and the midpoint between them, rounded down, is loaded as the final clock delay. The controller also reports both edges, the chosen position, a 32-bit map of the positions that passed, a fail flag for the case where no position passed, and a flag for the case where the eye was not closed on both sides. One delay step is about 78 ps, so a full sweep spans about 2418 ps. The parameter `SPAN_PS` gives this span as a constant. An eye can be bounded on both sides only when one unit interval fits inside that span.

Top module: `eye_cal_top`

## Requirements
- R1: After reset, `done_o`, `tap_load_o`, `fail_o` and `open_o` are 0, and `tap_o`, `best_o`, `lo_edge_o`, `hi_edge_o` and `pass_map_o` are all 0.
- R2: A start request loads taps 0, 1, …, 31 in increasing order. Each load has a one-cycle `tap_load_o` pulse, and one more pulse loads the result, so there are 33 pulses per run.
- R3: After each sweep load, the controller ignores `rx_word_i` for `settle_i`+1 cycles. Only after that does the word comparison start.
- R4: A tap passes only if `rx_word_i` equals `train_i` on all of `check_i` consecutive cycles. A value of 0 counts as 1.
- R5: Bit i of `pass_map_o` is 1 exactly when tap i passed during the last run.
- R6: `lo_edge_o` and `hi_edge_o` are the first and last taps of the lowest contiguous run of passing taps. A passing tap that lies beyond a failing tap above this run is ignored.
- R7: When at least one tap passes, `best_o` and the final `tap_o` are equal to floor((`lo_edge_o`+`hi_edge_o`)/2).
- R8: When no tap passes, `fail_o` is 1, the final `tap_o`, `best_o`, `lo_edge_o` and `hi_edge_o` are all 0, and `done_o` still pulses.
- R9: `open_o` is 1 exactly when a window was found whose lower edge is tap 0 or whose upper edge is tap 31, so that no failing tap was seen on that side.
- R10: `done_o` pulses for a single cycle at the end of each run. A start request made while a run is in progress has no effect: that run goes on without restarting and yields only one done pulse.
- R11: `tap_o` changes only in a cycle where `tap_load_o` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, accepted only while idle |
| train_i | input | DATA_W | Expected training word |
| rx_word_i | input | DATA_W | Deserialized word captured with the current clock delay |
| settle_i | input | CNT_W | Settle cycles after each load, minus one |
| check_i | input | CNT_W | Number of words compared per tap |
| tap_o | output | TAP_W | Clock delay value for the delay element |
| tap_load_o | output | 1 | One-cycle load strobe for `tap_o` |
| done_o | output | 1 | One-cycle end-of-calibration pulse |
| fail_o | output | 1 | No tap passed |
| open_o | output | 1 | Window touches an end of the sweep |
| lo_edge_o | output | TAP_W | Lower edge of the eye |
| hi_edge_o | output | TAP_W | Upper edge of the eye |
| best_o | output | TAP_W | Chosen centre tap |
| pass_map_o | output | NUM_TAPS | Per-tap pass result |

## Verification
The assertions check on every cycle the following relations:
- strobes and done are single-cycle pulses;
- the tap value never moves without a load strobe;
- on done, the reported edges and the centre are consistent with each other and with the pass map;
- on a failed run, the tap is 0;
- the open flag appears only for a window that touches an end of the sweep.

Other behaviours can only be shown by the bench's scenarios. These are:
- that each tap is actually judged after the settle gap over all compared words;
- that a tap which fails only on some words is rejected;
- that an isolated passing tap above the window is ignored;
- that the rounding of the midpoint is correct;
- that a start request in the middle of a run has no effect.

// File: rtl/eye_cal_pkg.sv
package eye_cal_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_SETTLE, ST_CHECK, ST_NEXT, ST_COMPUTE, ST_APPLY, ST_DONE
  } cal_state_t;

  localparam int unsigned STEP_PS = 78;
endpackage

// File: rtl/eye_cal_match.sv
module eye_cal_match #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic [DATA_W-1:0] rx_i,
  input  logic [DATA_W-1:0] exp_i,
  output logic              match_o,
  output logic              ok_o
);
  assign match_o = (rx_i == exp_i);

  always_ff @(posedge clk) begin
    if (rst || clr_i) ok_o <= 1'b1;
    else if (en_i)    ok_o <= ok_o & match_o;
  end
endmodule

// File: rtl/eye_cal_window.sv
module eye_cal_window #(
  parameter int NUM_TAPS = 32,
  parameter int TAP_W    = 5
) (
  input  logic [NUM_TAPS-1:0] map_i,
  output logic                found_o,
  output logic [TAP_W-1:0]    lo_o,
  output logic [TAP_W-1:0]    hi_o
);
  logic in_run;

  always_comb begin
    found_o = 1'b0;
    in_run  = 1'b0;
    lo_o    = '0;
    hi_o    = '0;
    for (int i = 0; i < NUM_TAPS; i++) begin
      if (map_i[i]) begin
        if (!found_o) begin
          found_o = 1'b1;
          in_run  = 1'b1;
          lo_o    = TAP_W'(i);
          hi_o    = TAP_W'(i);
        end else if (in_run) begin
          hi_o = TAP_W'(i);
        end
      end else begin
        in_run = 1'b0;
      end
    end
  end
endmodule

// File: rtl/eye_cal_top.sv
module eye_cal_top #(
  parameter int NUM_TAPS = 32,
  parameter int DATA_W   = 8,
  parameter int CNT_W    = 8,
  parameter int TAP_W    = $clog2(NUM_TAPS),
  parameter int SPAN_PS  = (NUM_TAPS - 1) * eye_cal_pkg::STEP_PS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic [DATA_W-1:0]   train_i,
  input  logic [DATA_W-1:0]   rx_word_i,
  input  logic [CNT_W-1:0]    settle_i,
  input  logic [CNT_W-1:0]    check_i,
  output logic [TAP_W-1:0]    tap_o,
  output logic                tap_load_o,
  output logic                done_o,
  output logic                fail_o,
  output logic                open_o,
  output logic [TAP_W-1:0]    lo_edge_o,
  output logic [TAP_W-1:0]    hi_edge_o,
  output logic [TAP_W-1:0]    best_o,
  output logic [NUM_TAPS-1:0] pass_map_o
);
  import eye_cal_pkg::*;

  localparam logic [TAP_W-1:0] LAST_TAP = TAP_W'(NUM_TAPS - 1);

  cal_state_t       state;
  logic [TAP_W-1:0] tap_idx;
  logic [CNT_W-1:0] cnt;
  logic             settle_end, check_last;
  logic             word_match, word_ok;
  logic             win_found;
  logic [TAP_W-1:0] win_lo, win_hi;
  logic [TAP_W:0]   mid_sum;

  assign settle_end = (state == ST_SETTLE) && (cnt >= settle_i);
  assign check_last = ({1'b0, cnt} + 1'b1) >= {1'b0, check_i};
  assign mid_sum    = {1'b0, lo_edge_o} + {1'b0, hi_edge_o};

  eye_cal_match #(.DATA_W(DATA_W)) u_match (
    .clk     (clk),
    .rst     (rst),
    .clr_i   (settle_end),
    .en_i    (state == ST_CHECK),
    .rx_i    (rx_word_i),
    .exp_i   (train_i),
    .match_o (word_match),
    .ok_o    (word_ok)
  );

  eye_cal_window #(.NUM_TAPS(NUM_TAPS), .TAP_W(TAP_W)) u_window (
    .map_i   (pass_map_o),
    .found_o (win_found),
    .lo_o    (win_lo),
    .hi_o    (win_hi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      tap_idx    <= '0;
      cnt        <= '0;
      tap_o      <= '0;
      tap_load_o <= 1'b0;
      done_o     <= 1'b0;
      fail_o     <= 1'b0;
      open_o     <= 1'b0;
      lo_edge_o  <= '0;
      hi_edge_o  <= '0;
      best_o     <= '0;
      pass_map_o <= '0;
    end else begin
      tap_load_o <= 1'b0;
      done_o     <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start_i) begin
            pass_map_o <= '0;
            tap_idx    <= '0;
            state      <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          tap_o      <= tap_idx;
          tap_load_o <= 1'b1;
          cnt        <= '0;
          state      <= ST_SETTLE;
        end
        ST_SETTLE: begin
          if (settle_end) begin
            cnt   <= '0;
            state <= ST_CHECK;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_CHECK: begin
          cnt <= cnt + 1'b1;
          if (check_last) begin
            pass_map_o[tap_idx] <= word_ok & word_match;
            state               <= ST_NEXT;
          end
        end
        ST_NEXT: begin
          if (tap_idx == LAST_TAP) begin
            state <= ST_COMPUTE;
          end else begin
            tap_idx <= tap_idx + 1'b1;
            state   <= ST_LOAD;
          end
        end
        ST_COMPUTE: begin
          fail_o    <= !win_found;
          open_o    <= win_found && ((win_lo == '0) || (win_hi == LAST_TAP));
          lo_edge_o <= win_lo;
          hi_edge_o <= win_hi;
          state     <= ST_APPLY;
        end
        ST_APPLY: begin
          tap_o      <= fail_o ? '0 : mid_sum[TAP_W:1];
          best_o     <= fail_o ? '0 : mid_sum[TAP_W:1];
          tap_load_o <= 1'b1;
          done_o     <= 1'b1;
          state      <= ST_DONE;
        end
        ST_DONE: begin
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eye_cal_chk.sv
module eye_cal_chk #(
  parameter int NUM_TAPS = 32,
  parameter int TAP_W    = 5
) (
  input logic                clk,
  input logic                rst,
  input logic [TAP_W-1:0]    tap_o,
  input logic                tap_load_o,
  input logic                done_o,
  input logic                fail_o,
  input logic                open_o,
  input logic [TAP_W-1:0]    lo_edge_o,
  input logic [TAP_W-1:0]    hi_edge_o,
  input logic [TAP_W-1:0]    best_o,
  input logic [NUM_TAPS-1:0] pass_map_o
);
  localparam logic [TAP_W-1:0] LAST_TAP = TAP_W'(NUM_TAPS - 1);

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  a_r2_load_pulse: assert property (@(posedge clk) disable iff (rst)
    tap_load_o |=> !tap_load_o);

  a_r11_tap_moves_with_load: assert property (@(posedge clk) disable iff (rst)
    !$stable(tap_o) |-> tap_load_o);

  a_r8_fail_tap_zero: assert property (@(posedge clk) disable iff (rst)
    (done_o && fail_o) |-> (tap_o == '0 && best_o == '0 && lo_edge_o == '0 && hi_edge_o == '0));

  a_r7_best_in_window: assert property (@(posedge clk) disable iff (rst)
    (done_o && !fail_o) |-> (best_o >= lo_edge_o && best_o <= hi_edge_o && tap_o == best_o));

  a_r6_edges_pass: assert property (@(posedge clk) disable iff (rst)
    (done_o && !fail_o) |-> (pass_map_o[lo_edge_o] && pass_map_o[hi_edge_o]
                             && (lo_edge_o == '0 || !pass_map_o[lo_edge_o - 1'b1])));

  a_r9_open_edge: assert property (@(posedge clk) disable iff (rst)
    (done_o && open_o) |-> (!fail_o && (lo_edge_o == '0 || hi_edge_o == LAST_TAP)));
endmodule

bind eye_cal_top eye_cal_chk #(.NUM_TAPS(NUM_TAPS), .TAP_W(TAP_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .tap_o      (tap_o),
  .tap_load_o (tap_load_o),
  .done_o     (done_o),
  .fail_o     (fail_o),
  .open_o     (open_o),
  .lo_edge_o  (lo_edge_o),
  .hi_edge_o  (hi_edge_o),
  .best_o     (best_o),
  .pass_map_o (pass_map_o)
);

// File: tb/tb_eye_cal_top.sv
`timescale 1ns/1ps
module tb_eye_cal_top;
  localparam int NT = 32, TW = 5, DW = 8, CW = 8, GARB = 4;
  localparam logic [DW-1:0] TRAIN = 8'hA5;

  typedef struct packed {
    logic [TW-1:0] lo, hi, best;
    logic          fail, open;
    logic [NT-1:0] map;
  } exp_t;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [DW-1:0] rx_word = '0;
  logic [CW-1:0] settle = 8'd4, check = 8'd4;
  logic [TW-1:0] tap, lo_e, hi_e, best;
  logic tap_load, done, fail, open_f;
  logic [NT-1:0] pmap;
  logic [NT-1:0] good_map = '0, flaky_map = '0;

  int n_cmp = 0, n_bad = 0;
  int since_load = 0, loads = 0, exp_next = 0, seq_bad = 0, done_cnt = 0;
  bit phase = 1'b0;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  eye_cal_top dut (
    .clk(clk), .rst(rst), .start_i(start), .train_i(TRAIN), .rx_word_i(rx_word),
    .settle_i(settle), .check_i(check), .tap_o(tap), .tap_load_o(tap_load),
    .done_o(done), .fail_o(fail), .open_o(open_f), .lo_edge_o(lo_e),
    .hi_edge_o(hi_e), .best_o(best), .pass_map_o(pmap)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // Link model: garbage right after a load, then training word on good taps
  always @(negedge clk) begin
    phase <= ~phase;
    if (tap_load) since_load <= 0;
    else if (since_load < 1000) since_load <= since_load + 1;
  end
  always @(negedge clk) begin
    #0.1;
    if (since_load < GARB) rx_word = ~TRAIN;
    else if (good_map[tap] && !(flaky_map[tap] && phase)) rx_word = TRAIN;
    else rx_word = TRAIN ^ 8'h5A;
  end

  // Load-strobe monitor (R2)
  always @(negedge clk) begin
    if (!rst && tap_load) begin
      loads <= loads + 1;
      if (!done) begin
        if (tap !== TW'(exp_next)) seq_bad <= seq_bad + 1;
        exp_next <= exp_next + 1;
      end
    end
  end

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && done) begin
      done_cnt <= done_cnt + 1;
      if (exp_q.size() == 0) begin
        chk("R10", "unexpected done", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk("R5", "pass map", pmap, e.map);
        chk("R6", "lower edge", 32'(lo_e), 32'(e.lo));
        chk("R6", "upper edge", 32'(hi_e), 32'(e.hi));
        chk("R7", "best tap", 32'(best), 32'(e.best));
        chk("R7", "tap_o final", 32'(tap), 32'(e.best));
        chk("R8", "fail flag", 32'(fail), 32'(e.fail));
        chk("R9", "open flag", 32'(open_f), 32'(e.open));
      end
    end
  end

  task automatic run(input logic [CW-1:0] s, input logic [CW-1:0] c,
                     input logic [NT-1:0] g, input logic [NT-1:0] f,
                     input exp_t e, input bit poke);
    int d0;
    settle = s; check = c; good_map = g; flaky_map = f;
    exp_q.push_back(e);
    @(negedge clk);
    loads = 0; exp_next = 0; seq_bad = 0;
    d0 = done_cnt;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (60) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    do @(negedge clk); while (!done);
    @(negedge clk);
    chk("R2", "load strobes", 32'(loads), 32'd33);
    chk("R2", "tap order errors", 32'(seq_bad), 32'd0);
    repeat (20) @(negedge clk);
    chk("R10", "done pulses per run", 32'(done_cnt - d0), 32'd1);
    chk("R11", "tap held after done", 32'(tap), 32'(e.best));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk("WDOG", "watchdog expired", 32'd1, 32'd0);
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "done", 32'(done), 0);
    chk("R1", "load", 32'(tap_load), 0);
    chk("R1", "fail/open", {30'd0, fail, open_f}, 0);
    chk("R1", "tap/best", {22'd0, tap, best}, 0);
    chk("R1", "edges", {22'd0, lo_e, hi_e}, 0);
    chk("R1", "map", pmap, 0);

    // R6 R7 centred window 10..20
    run(8'd4, 8'd4, 32'h001FFC00, '0, '{5'd10, 5'd20, 5'd15, 1'b0, 1'b0, 32'h001FFC00}, 1'b0);
    // R9 window touching tap 0
    run(8'd4, 8'd4, 32'h000000FF, '0, '{5'd0, 5'd7, 5'd3, 1'b0, 1'b1, 32'h000000FF}, 1'b0);
    // R8 no passing tap
    run(8'd4, 8'd4, 32'h0, '0, '{5'd0, 5'd0, 5'd0, 1'b1, 1'b0, 32'h0}, 1'b0);
    // R6 isolated pass at 25 ignored
    run(8'd4, 8'd4, 32'h020003E0, '0, '{5'd5, 5'd9, 5'd7, 1'b0, 1'b0, 32'h020003E0}, 1'b0);
    // R7 rounding down, window 12..13
    run(8'd4, 8'd4, 32'h00003000, '0, '{5'd12, 5'd13, 5'd12, 1'b0, 1'b0, 32'h00003000}, 1'b0);
    // R4 tap 15 fails on alternate words only
    run(8'd4, 8'd4, 32'h001FFC00, 32'h00008000, '{5'd10, 5'd14, 5'd12, 1'b0, 1'b0, 32'h001F7C00}, 1'b0);
    // R3 settle too short: garbage reaches the check window
    run(8'd0, 8'd4, 32'hFFFFFFFF, '0, '{5'd0, 5'd0, 5'd0, 1'b1, 1'b0, 32'h0}, 1'b0);
    // R3 enough settle with every tap good, single-word check (R4)
    run(8'd4, 8'd1, 32'hFFFFFFFF, '0, '{5'd0, 5'd31, 5'd15, 1'b0, 1'b1, 32'hFFFFFFFF}, 1'b0);
    // R10 start during run ignored; R9 window touching tap 31
    run(8'd4, 8'd4, 32'hFF000000, '0, '{5'd24, 5'd31, 5'd27, 1'b0, 1'b1, 32'hFF000000}, 1'b1);

    chk("R10", "scoreboard drained", 32'(exp_q.size()), 32'd0);
    summary();
    $finish;
  end
endmodule